// File: doc/BRIEF.md
# Adjustable Precision Time Counter

This block keeps a free-running nanosecond count for packet timestamping. On every cycle of the reference clock in which the timer runs, the count grows by a programmable step. A correction period lets software swap in a second, slightly different step on a fixed cadence, so the average rate can be trimmed in very fine steps without touching the clock. The count can wrap at a programmable period value instead of at the full word width, and an overflow pulse marks each such wrap.

Software talks to the block through a simple 32-bit register port with a word index. It can load the count directly, clear it with a self-clearing restart bit, and take a coherent snapshot of the running count with a self-clearing capture bit. Reads of the count register return that snapshot. A two-state controller (HALT, RUN) gates the counting. The `start` transition goes from HALT to RUN on a control write with the enable bit set. The `stop` transition goes from RUN to HALT on a control write with the enable bit clear. Any other cycle keeps the current state.

Register words (index on `reg_addr`): 0 control, 1 count, 2 wrap period, 3 correction period, 4 step.

Top module: `tpc_top`

## Requirements
- R1: After reset, the control, count, wrap period, correction period and step words all read 0, and `ovf_pulse` is low.
- R2: In RUN (control bit 0 = 1) the count grows by the normal step (step word bits 6:0) on every clock edge. In HALT the count holds.
- R3: The step word bits 14:8 hold the correction step. With a nonzero correction period P, every (P+1)-th running edge adds the correction step instead of the normal step. With P = 0 the correction step has no effect.
- R4: With control bit 5 set and a nonzero wrap period W, a running edge whose sum reaches or passes W stores the sum minus W. W = 0x8000_0000 with step 1 gives a 31-bit count that goes from 0x7FFF_FFFF to 0.
- R5: `ovf_pulse` is high for the one cycle after each wrapping edge, and only when control bit 4 is set. With bit 4 clear, wraps still happen but the pulse stays low.
- R6: A control write with bit 11 set latches the count held before that edge. Reads of the count word return this snapshot until the next capture. Bit 11 reads 1 for one cycle after the write and 0 afterwards.
- R7: A write to the count word replaces the count at that edge, in HALT or RUN. The load takes priority over that edge's step.
- R8: A control write with bit 9 set clears the count and the correction phase at that edge. Bit 9 reads 1 for one cycle after the write and 0 afterwards.
- R9: Control bits 0, 4 and 5 read back as written. The step word reads back only its two 7-bit fields, at bits 6:0 and 14:8. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ovf_pulse | output | 1 | One-cycle pulse on a wrap at the period value |

## Verification
The count is driven with a plain normal step, with a mixed step in which the correction step appears on a fixed cadence, and with a correction period of zero. Comparing the mixed run against the zero-period run separates a correct cadence from a correction step that leaks in or is never used. Wrap runs start just below a small period and just below 0x8000_0000; a run with the event enable off tells the wrap arithmetic apart from the pulse gating. Loads and restarts issued mid-run check the priority over the step and the reset of the correction phase, the latter by landing where a stale phase would add a different total.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
    // register word indices
    localparam int unsigned WRD_CTRL   = 0;
    localparam int unsigned WRD_COUNT  = 1;
    localparam int unsigned WRD_PERIOD = 2;
    localparam int unsigned WRD_CORR   = 3;
    localparam int unsigned WRD_STEP   = 4;

    // control bit positions
    localparam int unsigned CB_ENABLE  = 0;
    localparam int unsigned CB_EVT     = 4;
    localparam int unsigned CB_WRAP    = 5;
    localparam int unsigned CB_RESTART = 9;
    localparam int unsigned CB_CAPTURE = 11;

    // correction step field low bit in the step word
    localparam int unsigned STEP_CORR_LSB = 8;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } tpc_state_e;
endpackage

// File: rtl/tpc_regs.sv
module tpc_regs
    import tpc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STEP_W = 7,
    parameter int unsigned AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] snap_i,
    output logic              run_o,
    output logic              evt_en_o,
    output logic              wrap_en_o,
    output logic              cap_req_o,
    output logic              restart_o,
    output logic              load_we_o,
    output logic [DATA_W-1:0] period_o,
    output logic [DATA_W-1:0] corr_per_o,
    output logic [STEP_W-1:0] step_norm_o,
    output logic [STEP_W-1:0] step_corr_o,
    output logic              cap_flag_o,
    output logic              rst_flag_o
);
    tpc_state_e state_q, state_d;
    logic ctrl_wr;

    assign ctrl_wr   = bus_we && (bus_addr == AW'(WRD_CTRL));
    assign cap_req_o = ctrl_wr && bus_wdata[CB_CAPTURE];
    assign restart_o = ctrl_wr && bus_wdata[CB_RESTART];
    assign load_we_o = bus_we && (bus_addr == AW'(WRD_COUNT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: start (HALT->RUN), stop (RUN->HALT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && bus_wdata[CB_ENABLE])  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !bus_wdata[CB_ENABLE]) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            ST_HALT: run_o = 1'b0;
            ST_RUN:  run_o = 1'b1;
            default: run_o = 1'b0;
        endcase
    end

    // configuration and self-clearing flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_en_o    <= 1'b0;
            wrap_en_o   <= 1'b0;
            cap_flag_o  <= 1'b0;
            rst_flag_o  <= 1'b0;
            period_o    <= '0;
            corr_per_o  <= '0;
            step_norm_o <= '0;
            step_corr_o <= '0;
        end else begin
            cap_flag_o <= cap_req_o;
            rst_flag_o <= restart_o;
            if (ctrl_wr) begin
                evt_en_o  <= bus_wdata[CB_EVT];
                wrap_en_o <= bus_wdata[CB_WRAP];
            end
            if (bus_we && bus_addr == AW'(WRD_PERIOD)) period_o   <= bus_wdata;
            if (bus_we && bus_addr == AW'(WRD_CORR))   corr_per_o <= bus_wdata;
            if (bus_we && bus_addr == AW'(WRD_STEP)) begin
                step_norm_o <= bus_wdata[STEP_W-1:0];
                step_corr_o <= bus_wdata[STEP_CORR_LSB +: STEP_W];
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(WRD_CTRL): begin
                bus_rdata[CB_ENABLE]  = run_o;
                bus_rdata[CB_EVT]     = evt_en_o;
                bus_rdata[CB_WRAP]    = wrap_en_o;
                bus_rdata[CB_RESTART] = rst_flag_o;
                bus_rdata[CB_CAPTURE] = cap_flag_o;
            end
            AW'(WRD_COUNT):  bus_rdata = snap_i;
            AW'(WRD_PERIOD): bus_rdata = period_o;
            AW'(WRD_CORR):   bus_rdata = corr_per_o;
            AW'(WRD_STEP): begin
                bus_rdata[STEP_W-1:0]               = step_norm_o;
                bus_rdata[STEP_CORR_LSB +: STEP_W]  = step_corr_o;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tpc_rate.sv
module tpc_rate #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [DATA_W-1:0] corr_per_i,
    input  logic [STEP_W-1:0] step_norm_i,
    input  logic [STEP_W-1:0] step_corr_i,
    output logic [STEP_W-1:0] step_o
);
    logic [DATA_W-1:0] phase_q;
    logic corr_on, corr_due;

    assign corr_on  = (corr_per_i != '0);
    assign corr_due = corr_on && (phase_q >= corr_per_i);
    assign step_o   = corr_due ? step_corr_i : step_norm_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            if (!corr_on || corr_due) phase_q <= '0;
            else                      phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tpc_accum.sv
module tpc_accum #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic              load_we_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              wrap_en_i,
    input  logic              evt_en_i,
    input  logic [DATA_W-1:0] period_i,
    input  logic              cap_req_i,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] snap_o,
    output logic              ovf_o
);
    localparam int unsigned SUM_W = DATA_W + 1;

    logic [SUM_W-1:0]  sum;
    logic              wrap_hit;
    logic [DATA_W-1:0] next_cnt;

    assign sum      = {1'b0, count_o} + SUM_W'(step_i);
    assign wrap_hit = wrap_en_i && (period_i != '0) && (sum >= {1'b0, period_i});
    assign next_cnt = wrap_hit ? DATA_W'(sum - {1'b0, period_i}) : sum[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
        end else begin
            ovf_o <= 1'b0;
            if (restart_i) begin
                count_o <= '0;
            end else if (load_we_i) begin
                count_o <= load_val_i;
            end else if (run_i) begin
                count_o <= next_cnt;
                ovf_o   <= wrap_hit && evt_en_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_o <= '0;
        else if (cap_req_i) snap_o <= count_o;
    end
endmodule

// File: rtl/tpc_top.sv
module tpc_top #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STEP_W = 7,
    parameter int unsigned AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ovf_pulse
);
    logic              run, evt_en, wrap_en, cap_req, restart, load_we;
    logic              cap_flag, rst_flag;
    logic [DATA_W-1:0] period, corr_per, snap, count;
    logic [STEP_W-1:0] step_norm, step_corr, step;

    tpc_regs #(.DATA_W(DATA_W), .STEP_W(STEP_W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(reg_we), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
        .snap_i(snap),
        .run_o(run), .evt_en_o(evt_en), .wrap_en_o(wrap_en),
        .cap_req_o(cap_req), .restart_o(restart), .load_we_o(load_we),
        .period_o(period), .corr_per_o(corr_per),
        .step_norm_o(step_norm), .step_corr_o(step_corr),
        .cap_flag_o(cap_flag), .rst_flag_o(rst_flag)
    );

    tpc_rate #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_rate (
        .clk(clk), .rst_n(rst_n),
        .run_i(run), .restart_i(restart), .corr_per_i(corr_per),
        .step_norm_i(step_norm), .step_corr_i(step_corr), .step_o(step)
    );

    tpc_accum #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_accum (
        .clk(clk), .rst_n(rst_n),
        .run_i(run), .restart_i(restart), .load_we_i(load_we), .load_val_i(reg_wdata),
        .step_i(step), .wrap_en_i(wrap_en), .evt_en_i(evt_en), .period_i(period),
        .cap_req_i(cap_req), .count_o(count), .snap_o(snap), .ovf_o(ovf_pulse)
    );
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovf,
    input logic              run,
    input logic              evt_en,
    input logic              load_we,
    input logic              restart,
    input logic              cap_flag,
    input logic              rst_flag,
    input logic [DATA_W-1:0] count
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_we && !restart) |=> $stable(count)); // R2

    AST_OVF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(run && evt_en)); // R5

    AST_CAP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cap_flag |=> !cap_flag); // R6

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_flag |-> (count == '0)); // R8

    AST_RESTART_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_flag |=> !rst_flag); // R8
endmodule

bind tpc_top tpc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_pulse), .run(run), .evt_en(evt_en),
    .load_we(load_we), .restart(restart), .cap_flag(cap_flag),
    .rst_flag(rst_flag), .count(count)
);

// File: tb/tb_tpc_top.sv
module tb_tpc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ovf_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_PER = 3'd2, A_CORR = 3'd3, A_STEP = 3'd4;

    tpc_top dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_pulse(ovf_pulse)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // capture then read the snapshot
    task automatic snap_read(input logic [31:0] keep, output logic [31:0] d);
        wr(A_CTRL, keep | 32'h800);
        rd(A_CNT, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_CNT, d);  chk("R1 count", d, 0);
        rd(A_PER, d);  chk("R1 period", d, 0);
        rd(A_CORR, d); chk("R1 corr", d, 0);
        rd(A_STEP, d); chk("R1 step", d, 0);
        chk("R1 ovf", {31'b0, ovf_pulse}, 0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr(A_STEP, 32'hFFFF_FFFF);
        rd(A_STEP, d); chk("R9 step fields", d, 32'h0000_7F7F);
        wr(A_CTRL, 32'h31);
        rd(A_CTRL, d); chk("R9 ctrl bits", d, 32'h31);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d); chk("R9 ctrl clear", d, 0);
    endtask

    task automatic t_run_hold;
        logic [31:0] d;
        wr(A_STEP, 32'h0000_0005);
        wr(A_CORR, 0);
        wr(A_CTRL, 32'h200);
        wr(A_CTRL, 32'h1);
        idle(9);
        wr(A_CTRL, 32'h0);
        snap_read(0, d); chk("R2 ten steps of 5", d, 50);
        rd(A_CTRL, d);   chk("R6 capture bit set", d, 32'h800);
        idle(1);
        rd(A_CTRL, d);   chk("R6 capture bit cleared", d, 0);
        idle(5);
        snap_read(0, d); chk("R2 halt holds", d, 50);
    endtask

    task automatic t_corr;
        logic [31:0] d;
        wr(A_STEP, 32'h0000_0908);
        wr(A_CORR, 2);
        wr(A_CTRL, 32'h200);
        wr(A_CTRL, 32'h1);
        idle(8);
        wr(A_CTRL, 32'h0);
        snap_read(0, d); chk("R3 every third step corrected", d, 75);
        wr(A_CORR, 0);
        wr(A_CTRL, 32'h200);
        wr(A_CTRL, 32'h1);
        idle(8);
        wr(A_CTRL, 32'h0);
        snap_read(0, d); chk("R3 zero period ignores correction", d, 72);
    endtask

    task automatic t_wrap_evt;
        logic [31:0] d;
        wr(A_PER, 100);
        wr(A_STEP, 7);
        wr(A_CNT, 90);
        snap_read(0, d); chk("R7 load while halted", d, 90);
        wr(A_CTRL, 32'h31);
        chk("R5 no pulse yet", {31'b0, ovf_pulse}, 0);
        idle(1);
        chk("R5 no pulse at 97", {31'b0, ovf_pulse}, 0);
        idle(1);
        chk("R5 pulse after wrap", {31'b0, ovf_pulse}, 1);
        idle(1);
        chk("R5 pulse one cycle", {31'b0, ovf_pulse}, 0);
        wr(A_CTRL, 32'h30);
        snap_read(32'h30, d); chk("R4 wrap keeps remainder", d, 18);
    endtask

    task automatic t_wrap_quiet;
        logic [31:0] d;
        int seen = 0;
        wr(A_CNT, 90);
        wr(A_CTRL, 32'h21);
        for (int i = 0; i < 3; i++) begin
            idle(1);
            if (ovf_pulse) seen++;
        end
        wr(A_CTRL, 32'h20);
        chk("R5 event disabled no pulse", seen, 0);
        snap_read(32'h20, d); chk("R4 wrap without event", d, 18);
    endtask

    task automatic t_wrap31;
        logic [31:0] d;
        wr(A_PER, 32'h8000_0000);
        wr(A_STEP, 1);
        wr(A_CNT, 32'h7FFF_FFFE);
        wr(A_CTRL, 32'h31);
        idle(1);
        chk("R5 no pulse at top", {31'b0, ovf_pulse}, 0);
        idle(1);
        chk("R5 pulse at 31-bit wrap", {31'b0, ovf_pulse}, 1);
        wr(A_CTRL, 32'h30);
        snap_read(32'h30, d); chk("R4 31-bit wrap to zero", d, 1);
    endtask

    task automatic t_load_run;
        logic [31:0] d;
        wr(A_PER, 0);
        wr(A_STEP, 3);
        wr(A_CTRL, 32'h200);
        wr(A_CTRL, 32'h1);
        idle(2);
        wr(A_CNT, 1000);
        idle(1);
        wr(A_CTRL, 32'h0);
        snap_read(0, d); chk("R7 load beats step", d, 1006);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        wr(A_STEP, 5);
        wr(A_CORR, 0);
        wr(A_CTRL, 32'h1);
        idle(3);
        wr(A_CTRL, 32'h201);
        rd(A_CTRL, d); chk("R8 restart bit set", d, 32'h201);
        idle(1);
        rd(A_CTRL, d); chk("R8 restart bit cleared", d, 32'h1);
        wr(A_CTRL, 32'h0);
        snap_read(0, d); chk("R8 count cleared", d, 10);
        // phase reset: stale phase would give 17
        wr(A_STEP, 32'h0000_0908);
        wr(A_CORR, 2);
        wr(A_CTRL, 32'h200);
        wr(A_CTRL, 32'h1);
        idle(4);
        wr(A_CTRL, 32'h201);
        idle(1);
        wr(A_CTRL, 32'h0);
        snap_read(0, d); chk("R8 correction phase cleared", d, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_run_hold();
        t_corr();
        t_wrap_evt();
        t_wrap_quiet();
        t_wrap31();
        t_load_run();
        t_restart();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule